// File: doc/BRIEF.md
# Peripheral Write Guard with Key-Sequence Unlock

This block keeps firmware from changing peripheral configuration by accident. It holds two lock registers. Each bit of a lock register stands for one group of peripherals. While a group's bit is set, every write aimed at that group is dropped in the same cycle it appears. Reads of that group always go through.

The lock registers are themselves protected. They accept new values only after two exact words have been written, in order, to a KEY register. Any later write to KEY closes them again. A read of KEY returns where the unlock sequence currently stands.

Configuration uses a small register bus: a 2-bit word address, a write strobe, write data and combinational read data. The address map is 0 = KEY, 1 = lock register A (groups 0..7), 2 = lock register B (groups 8..15), and 3 = unused. A peripheral access arrives as a write or read strobe together with a 4-bit group index. The block returns one-hot allow vectors and a blocked-write flag.

The key tracker is a three-state machine:
- `KS_LOCKED` (read value 0) moves to `KS_HALF` on a KEY write of exactly 0x000000A5. Any other KEY write leaves it in `KS_LOCKED`.
- `KS_HALF` (read value 1) moves to `KS_OPEN` on a KEY write of exactly 0x000000F1. Any other KEY write sends it back to `KS_LOCKED`.
- `KS_OPEN` (read value 2) moves to `KS_LOCKED` on any KEY write.

Top module: `periph_lock_ctrl`

## Requirements
- R1: After reset, KEY reads 0, both lock registers read 0, and every group is writable.
- R2: A KEY write of 0xA5 from the locked state makes KEY read 1. A following KEY write of 0xF1 makes KEY read 2 (unlocked). Both values are compared as full 32-bit words.
- R3: Any other KEY write in the locked state keeps KEY at 0. Any KEY write other than 0xF1 in state 1, including a second 0xA5, returns KEY to 0.
- R4: Any KEY write while KEY reads 2 returns KEY to 0, whatever the data, and that write does not count as a first key.
- R5: Writes to either lock register while KEY reads 0 or 1 are ignored, and the register keeps its contents.
- R6: While KEY reads 2, a write to lock register A stores wdata[7:0] as the lock bits of groups 0..7. A write to lock register B stores wdata[7:0] as the lock bits of groups 8..15. Bits [31:8] are dropped and read back as 0.
- R7: A peripheral write to group g whose lock bit is clear raises only bit g of `p_we_ok`, with `p_blocked` low, in the same cycle.
- R8: A peripheral write to group g whose lock bit is set gives `p_we_ok` = 0 and `p_blocked` = 1 in the same cycle. With no write strobe, both are 0.
- R9: A peripheral read to group g raises bit g of `p_re_ok` whatever the lock bits are.
- R10: Relocking through KEY leaves the lock bits unchanged. Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 2 | Register word address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| p_we | input | 1 | Peripheral write strobe |
| p_re | input | 1 | Peripheral read strobe |
| p_grp | input | 4 | Group index of the peripheral access |
| p_we_ok | output | 16 | One-hot write allow per group |
| p_re_ok | output | 16 | One-hot read allow per group |
| p_blocked | output | 1 | Peripheral write dropped this cycle |

## Verification
The assertions check these rules on every cycle:
- the lock bits stay stable unless the tracker is open and a lock register is written (R5);
- a KEY write from the open state always relocks (R4), and a correct second key always opens (R2);
- a write to a locked group is never allowed and is flagged as blocked (R8), and an unlocked write is one-hot and unflagged (R7);
- reads are always granted (R9).

Only the bench's scenarios can show the rest:
- the exact values read back from KEY and the lock registers;
- the bit-to-group mapping;
- recovery from wrong-order sequences such as F1 then A5, or A5 then A5;
- lock bits surviving a relock.

// File: rtl/plk_pkg.sv
package plk_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam int unsigned ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] A_KEY   = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOCKA = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOCKB = 2'd2;
endpackage

// File: rtl/plk_key_fsm.sv
module plk_key_fsm
    import plk_pkg::*;
#(
    parameter int unsigned          DATA_W     = 32,
    parameter logic [DATA_W-1:0]    KEY_FIRST  = 32'h0000_00A5,
    parameter logic [DATA_W-1:0]    KEY_SECOND = 32'h0000_00F1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output key_state_t        state,
    output logic              is_open
);
    key_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KS_LOCKED: state_d = (key_val == KEY_FIRST)  ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_d = (key_val == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   state_d = KS_LOCKED;
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        is_open = (state_q == KS_OPEN);
    end
endmodule

// File: rtl/plk_lock_regs.sv
module plk_lock_regs #(
    parameter int unsigned GRP_PER_REG = 8,
    parameter int unsigned N_REGS      = 2,
    localparam int unsigned NGRP       = GRP_PER_REG * N_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   is_open,
    input  logic [N_REGS-1:0]      reg_wr,
    input  logic [GRP_PER_REG-1:0] wr_bits,
    output logic [NGRP-1:0]        lock_vec
);
    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        logic [GRP_PER_REG-1:0] bits_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (is_open && reg_wr[r]) begin
                bits_q <= wr_bits;
            end
        end
        assign lock_vec[r*GRP_PER_REG +: GRP_PER_REG] = bits_q;
    end
endmodule

// File: rtl/plk_write_gate.sv
module plk_write_gate #(
    parameter int unsigned NGRP  = 16,
    localparam int unsigned GRP_W = $clog2(NGRP)
) (
    input  logic             p_we,
    input  logic             p_re,
    input  logic [GRP_W-1:0] p_grp,
    input  logic [NGRP-1:0]  lock_vec,
    output logic [NGRP-1:0]  p_we_ok,
    output logic [NGRP-1:0]  p_re_ok,
    output logic             p_blocked
);
    logic [NGRP-1:0] hit;
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign hit[g]     = (p_grp == GRP_W'(g));
        assign p_we_ok[g] = p_we & hit[g] & ~lock_vec[g];
        assign p_re_ok[g] = p_re & hit[g];
    end
    assign p_blocked = p_we & |(hit & lock_vec);
endmodule

// File: rtl/periph_lock_ctrl.sv
module periph_lock_ctrl
    import plk_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned GRP_PER_REG = 8,
    localparam int unsigned NGRP       = 2 * GRP_PER_REG,
    localparam int unsigned GRP_W      = $clog2(NGRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_addr,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              p_we,
    input  logic              p_re,
    input  logic [GRP_W-1:0]  p_grp,
    output logic [NGRP-1:0]   p_we_ok,
    output logic [NGRP-1:0]   p_re_ok,
    output logic              p_blocked
);
    key_state_t      key_state;
    logic            is_open;
    logic [NGRP-1:0] lock_vec;
    logic [1:0]      reg_wr;
    logic            key_wr;

    assign key_wr    = cfg_we && (cfg_addr == A_KEY);
    assign reg_wr[0] = cfg_we && (cfg_addr == A_LOCKA);
    assign reg_wr[1] = cfg_we && (cfg_addr == A_LOCKB);

    plk_key_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (cfg_wdata),
        .state   (key_state),
        .is_open (is_open)
    );

    plk_lock_regs #(.GRP_PER_REG(GRP_PER_REG), .N_REGS(2)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_open  (is_open),
        .reg_wr   (reg_wr),
        .wr_bits  (cfg_wdata[GRP_PER_REG-1:0]),
        .lock_vec (lock_vec)
    );

    logic unused_hi;
    assign unused_hi = ^cfg_wdata[DATA_W-1:GRP_PER_REG];

    plk_write_gate #(.NGRP(NGRP)) u_gate (
        .p_we      (p_we),
        .p_re      (p_re),
        .p_grp     (p_grp),
        .lock_vec  (lock_vec),
        .p_we_ok   (p_we_ok),
        .p_re_ok   (p_re_ok),
        .p_blocked (p_blocked)
    );

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            A_KEY:   cfg_rdata = DATA_W'(key_state);
            A_LOCKA: cfg_rdata = DATA_W'(lock_vec[GRP_PER_REG-1:0]);
            A_LOCKB: cfg_rdata = DATA_W'(lock_vec[NGRP-1:GRP_PER_REG]);
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/plk_chk.sv
module plk_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NGRP   = 16,
    localparam int unsigned GRP_W = $clog2(NGRP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_addr,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [1:0]        key_state,
    input logic [NGRP-1:0]   lock_vec,
    input logic              p_we,
    input logic              p_re,
    input logic [GRP_W-1:0]  p_grp,
    input logic [NGRP-1:0]   p_we_ok,
    input logic [NGRP-1:0]   p_re_ok,
    input logic              p_blocked
);
    logic key_w, lock_w;
    assign key_w  = cfg_we && (cfg_addr == 2'd0);
    assign lock_w = cfg_we && (cfg_addr == 2'd1 || cfg_addr == 2'd2);

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_w && key_state == 2'd2) |=> $stable(lock_vec));

    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_w && key_state == 2'd2) |=> (key_state == 2'd0));

    // R2
    open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_w && key_state == 2'd1 && cfg_wdata == 32'h0000_00F1) |=> (key_state == 2'd2));

    // R8
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && lock_vec[p_grp]) |-> (p_blocked && p_we_ok == '0));

    // R7
    allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && !lock_vec[p_grp]) |-> ($onehot(p_we_ok) && !p_blocked));

    // R9
    read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_re |-> $onehot(p_re_ok));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_we |-> (p_we_ok == '0 && !p_blocked));
endmodule

bind periph_lock_ctrl plk_chk #(.DATA_W(DATA_W), .NGRP(NGRP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .key_state (key_state),
    .lock_vec  (lock_vec),
    .p_we      (p_we),
    .p_re      (p_re),
    .p_grp     (p_grp),
    .p_we_ok   (p_we_ok),
    .p_re_ok   (p_re_ok),
    .p_blocked (p_blocked)
);

// File: tb/periph_lock_ctrl_tb.sv
module periph_lock_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        p_we = 1'b0, p_re = 1'b0;
    logic [3:0]  p_grp = '0;
    logic [15:0] p_we_ok, p_re_ok;
    logic        p_blocked;

    int checks = 0, failures = 0;
    bit done = 0;
    int   m_state = 0;
    logic [15:0] m_lock = '0;

    always #5 clk = ~clk;

    periph_lock_ctrl u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int next_key(int s, logic [31:0] d);
        if (s == 2) return 0;
        if (s == 0) return (d == 32'hA5) ? 1 : 0;
        return (d == 32'hF1) ? 2 : 0;
    endfunction

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk);
        if (a == 2'd0) m_state = next_key(m_state, d);
        else if (a == 2'd1 && m_state == 2) m_lock[7:0] = d[7:0];
        else if (a == 2'd2 && m_state == 2) m_lock[15:8] = d[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_chk(logic [1:0] a, string req);
        logic [31:0] e;
        @(negedge clk);
        cfg_addr = a; cfg_we = 1'b0;
        #1;
        case (a)
            2'd0: e = 32'(m_state);
            2'd1: e = {24'd0, m_lock[7:0]};
            2'd2: e = {24'd0, m_lock[15:8]};
            default: e = 32'd0;
        endcase
        check(req, cfg_rdata, e);
    endtask

    task automatic periph(logic [3:0] g, string req);
        @(negedge clk);
        p_we = 1'b1; p_re = 1'b1; p_grp = g;
        #1;
        check({req, " we_ok"}, {16'd0, p_we_ok}, m_lock[g] ? 32'd0 : (32'd1 << g));
        check({req, " blocked"}, {31'd0, p_blocked}, {31'd0, m_lock[g]});
        check("R9 re_ok", {16'd0, p_re_ok}, 32'd1 << g);
        @(negedge clk);
        p_we = 1'b0; p_re = 1'b0;
        #1;
        check("R8 idle", {15'd0, p_blocked, p_we_ok}, 32'd0);
    endtask

    task automatic unlock();
        reg_wr(2'd0, 32'hA5);
        reg_wr(2'd0, 32'hF1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        reg_chk(2'd0, "R1 key");
        reg_chk(2'd1, "R1 lockA");
        reg_chk(2'd2, "R1 lockB");
        periph(4'd3, "R1");
        // R5 locked writes ignored
        reg_wr(2'd1, 32'hFF);
        reg_chk(2'd1, "R5 lockA");
        // R3 wrong order
        reg_wr(2'd0, 32'hF1); reg_chk(2'd0, "R3 F1 first");
        reg_wr(2'd0, 32'hA5); reg_chk(2'd0, "R2 half");
        reg_wr(2'd2, 32'hFF); reg_chk(2'd2, "R5 half lockB");
        reg_wr(2'd0, 32'hA5); reg_chk(2'd0, "R3 A5 twice");
        reg_wr(2'd0, 32'h1A5); reg_chk(2'd0, "R2 full-word compare");
        // R2 unlock, R6 program
        unlock(); reg_chk(2'd0, "R2 open");
        reg_wr(2'd1, 32'hFFFF_FF81); reg_chk(2'd1, "R6 lockA");
        reg_wr(2'd2, 32'h0000_0140); reg_chk(2'd2, "R6 lockB");
        // R4 relock with A5, R10 bits kept
        reg_wr(2'd0, 32'hA5); reg_chk(2'd0, "R4 relock");
        reg_chk(2'd1, "R10 keep A");
        periph(4'd0, "R8"); periph(4'd7, "R8"); periph(4'd14, "R8");
        periph(4'd1, "R7"); periph(4'd8, "R7");
        reg_wr(2'd3, 32'hFF); reg_chk(2'd3, "R10 addr3");
        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 5);
            logic [31:0] d;
            case ($urandom_range(0, 2))
                0: d = 32'hA5;
                1: d = 32'hF1;
                default: d = $urandom;
            endcase
            case (op)
                0: reg_wr(2'd0, d);
                1: unlock();
                2: reg_wr(2'($urandom_range(1, 3)), $urandom);
                3: reg_chk(2'($urandom_range(0, 3)), "R2-R6 random read");
                default: periph(4'($urandom_range(0, 15)), "R7/R8 random");
            endcase
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule